// File: doc/BRIEF.md
# I2C Master Transfer Sequencer with 10-bit Addressing

This block turns command words into the ordered list of byte-level bus operations an I2C master performs: start or repeated start, one or two address bytes, write or read data bytes, and stop. It handles 7-bit targets, 10-bit targets, and the repeated-start read form of 10-bit addressing. In that form a second command resends only the 11110xx header with the read bit set. A downstream bit engine carries out each operation and returns one completion pulse. That pulse carries the target's acknowledge bit for writes and the received byte for reads.

Software writes a current command to start a transfer. It may also place one queued command in a second slot. The queued command runs only after the current one has finished cleanly. Write payload comes in through a valid/ready byte port, and read payload goes out through another.

Top module: `i2c_addr_seq`

## Requirements
- R1: A command word has address in bits 9:0, ten-bit enable in bit 10, same-address-repeat in bit 11, read in bit 12, start in bit 13, stop in bit 14 and byte count from bit 15 up. `cur_wr` in idle starts that command. After reset `busy`, `op_valid`, `done`, `rx_valid` and `tx_ready` are all 0.
- R2: With ten-bit enable clear, the address phase is one WRITE operation (code 3) whose byte is address bits 6:0 followed by the read flag in bit 0.
- R3: With ten-bit enable set and same-address-repeat clear, the address phase is two WRITE operations. The first carries 11110, address bits 9:8 and the read flag. The second carries address bits 7:0.
- R4: With ten-bit enable and same-address-repeat both set, only the 11110xx header byte is written.
- R5: The first operation of a command with start set is START (code 1) when the bus is free. It is RSTART (code 2) when the previous command left the bus held.
- R6: In a write, each of the counted bytes is taken from the tx port and issued as a WRITE operation. A command with stop set ends with STOP (code 6).
- R7: In a read, every byte is fetched with READ_ACK (code 4) except the last, which uses READ_NACK (code 5). Each byte is offered on `rx_data` with `rx_valid` and stays stable until `rx_ready`.
- R8: A byte count of 0 skips the data phase. A command with stop clear issues no STOP, leaves the bus held, and drops `busy`.
- R9: A NACK on any address or written data byte issues STOP, pulses `nack_err` without `done`, and discards the queued command.
- R10: With `smbus_mode` high, a command with ten-bit enable set issues no operation, pulses `mode_err`, and discards the queued command.
- R11: Each cleanly completed command pulses `done` once. Only then is a queued command promoted and run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smbus_mode | input | 1 | Restrict to 7-bit addressing |
| cur_wr | input | 1 | Load and start current command (idle only) |
| cur_cmd | input | 15+NBW | Current command word |
| nxt_wr | input | 1 | Load the queued command slot |
| nxt_cmd | input | 15+NBW | Queued command word |
| busy | output | 1 | A command is in progress |
| done | output | 1 | Pulse: command completed cleanly |
| nack_err | output | 1 | Pulse: target NACKed, command aborted |
| mode_err | output | 1 | Pulse: 10-bit command rejected in SMBus mode |
| op_valid | output | 1 | Operation request to the bit engine |
| op_code | output | 3 | Operation code |
| op_data | output | 8 | Byte to write |
| op_done | input | 1 | Pulse: engine finished the operation |
| op_nack | input | 1 | Target NACKed the written byte |
| op_rdata | input | 8 | Byte received by a read operation |
| tx_valid | input | 1 | Write payload byte available |
| tx_data | input | 8 | Write payload byte |
| tx_ready | output | 1 | Payload byte accepted |
| rx_valid | output | 1 | Received byte available |
| rx_data | output | 8 | Received byte |
| rx_ready | input | 1 | Received byte taken |

## Verification
A 7-bit write, a 10-bit write and a chained 10-bit read are compared op by op against an expected stream. Together they separate the one-byte, two-byte and header-only address forms and the START and RSTART choice. A NACK on a data byte and a NACK on the header byte show the abort path from both phases. A follow-up command then shows that the discarded queued entry never runs. A rejected 10-bit command in SMBus mode, a zero-length read-flag-free write, a one-byte read, and a held bus that a later command reopens with RSTART cover the remaining mode and ending rules.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int ADDR_W = 10;
  localparam int F_TEN  = 10;
  localparam int F_REP  = 11;
  localparam int F_RD   = 12;
  localparam int F_STA  = 13;
  localparam int F_STO  = 14;
  localparam int F_NB   = 15;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_START   = 3'd1,
    OP_RSTART  = 3'd2,
    OP_WRITE   = 3'd3,
    OP_RD_ACK  = 3'd4,
    OP_RD_NACK = 3'd5,
    OP_STOP    = 3'd6
  } op_e;
endpackage

// File: rtl/i2c_addr_fmt.sv
module i2c_addr_fmt
  import i2c_seq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              ten,
  input  logic              rw,
  output logic [7:0]        hdr,
  output logic [7:0]        lo
);
  always_comb begin
    if (ten) hdr = {5'b11110, addr[9:8], rw};
    else     hdr = {addr[6:0], rw};
    lo = addr[7:0];
  end
endmodule

// File: rtl/i2c_cmd_slots.sv
module i2c_cmd_slots #(
  parameter int CMD_W = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_cur,
  input  logic [CMD_W-1:0] cur_in,
  input  logic             ld_nxt,
  input  logic [CMD_W-1:0] nxt_in,
  input  logic             promote,
  input  logic             discard,
  output logic [CMD_W-1:0] cur_out,
  output logic             nxt_valid
);
  logic [CMD_W-1:0] nxt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_out   <= '0;
      nxt_q     <= '0;
      nxt_valid <= 1'b0;
    end else begin
      if (ld_cur)       cur_out <= cur_in;
      else if (promote) cur_out <= nxt_q;
      if (ld_nxt) begin
        nxt_q     <= nxt_in;
        nxt_valid <= 1'b1;
      end else if (promote || discard) begin
        nxt_valid <= 1'b0;
      end
    end
  end

  // R11
  promote_has_entry_chk: assert property (@(posedge clk) disable iff (rst)
    promote |-> nxt_valid);
endmodule

// File: rtl/i2c_addr_seq.sv
module i2c_addr_seq
  import i2c_seq_pkg::*;
#(
  parameter  int NBW   = 8,
  localparam int CMD_W = F_NB + NBW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smbus_mode,
  input  logic             cur_wr,
  input  logic [CMD_W-1:0] cur_cmd,
  input  logic             nxt_wr,
  input  logic [CMD_W-1:0] nxt_cmd,
  output logic             busy,
  output logic             done,
  output logic             nack_err,
  output logic             mode_err,
  output logic             op_valid,
  output logic [2:0]       op_code,
  output logic [7:0]       op_data,
  input  logic             op_done,
  input  logic             op_nack,
  input  logic [7:0]       op_rdata,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  input  logic             rx_ready
);
  localparam logic [NBW-1:0] CNT_ONE = NBW'(1);

  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_START, S_ADR1, S_ADR2, S_DATA, S_WR,
    S_RD, S_RXO, S_END, S_STOP, S_FIN, S_ABRT
  } st_e;

  st_e              st;
  logic [CMD_W-1:0] cur;
  logic             nxt_valid;
  logic [NBW-1:0]   cnt;
  logic             held;
  logic [7:0]       hdr_b, lo_b;
  logic             promote, discard, nack_hit;

  wire c_ten = cur[F_TEN];
  wire c_rep = cur[F_REP];
  wire c_rd  = cur[F_RD];
  wire c_sta = cur[F_STA];
  wire c_sto = cur[F_STO];
  wire [NBW-1:0] c_nb = cur[F_NB +: NBW];

  assign nack_hit = op_done && op_nack &&
                    (st == S_ADR1 || st == S_ADR2 || st == S_WR);
  assign promote  = (st == S_FIN) && nxt_valid;
  assign discard  = nack_hit || ((st == S_LOAD) && c_ten && smbus_mode);
  assign busy     = (st != S_IDLE);
  assign tx_ready = (st == S_WR) && !op_valid;

  i2c_cmd_slots #(.CMD_W(CMD_W)) u_slots (
    .clk(clk), .rst(rst),
    .ld_cur(cur_wr && st == S_IDLE), .cur_in(cur_cmd),
    .ld_nxt(nxt_wr), .nxt_in(nxt_cmd),
    .promote(promote), .discard(discard),
    .cur_out(cur), .nxt_valid(nxt_valid)
  );

  i2c_addr_fmt u_fmt (
    .addr(cur[ADDR_W-1:0]), .ten(c_ten), .rw(c_rd),
    .hdr(hdr_b), .lo(lo_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      op_valid <= 1'b0;
      op_code  <= OP_NONE;
      op_data  <= '0;
      cnt      <= '0;
      held     <= 1'b0;
      done     <= 1'b0;
      nack_err <= 1'b0;
      mode_err <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      done     <= 1'b0;
      nack_err <= 1'b0;
      mode_err <= 1'b0;
      if (op_done) op_valid <= 1'b0;
      if (nack_hit) begin
        op_valid <= 1'b1; op_code <= OP_STOP; op_data <= '0;
        held <= 1'b0; nack_err <= 1'b1; st <= S_ABRT;
      end else begin
        case (st)
          S_IDLE: if (cur_wr) st <= S_LOAD;
          S_LOAD: begin
            cnt <= c_nb;
            if (c_ten && smbus_mode) begin
              mode_err <= 1'b1; st <= S_IDLE;
            end else if (c_sta) begin
              op_valid <= 1'b1; op_data <= '0;
              op_code  <= held ? OP_RSTART : OP_START;
              held <= 1'b1; st <= S_START;
            end else begin
              st <= S_DATA;
            end
          end
          S_START: if (op_done) begin
            op_valid <= 1'b1; op_code <= OP_WRITE; op_data <= hdr_b;
            st <= S_ADR1;
          end
          S_ADR1: if (op_done) begin
            if (c_ten && !c_rep) begin
              op_valid <= 1'b1; op_code <= OP_WRITE; op_data <= lo_b;
              st <= S_ADR2;
            end else begin
              st <= S_DATA;
            end
          end
          S_ADR2: if (op_done) st <= S_DATA;
          S_DATA: begin
            if (cnt == '0) st <= S_END;
            else if (c_rd) begin
              op_valid <= 1'b1; op_data <= '0;
              op_code  <= (cnt == CNT_ONE) ? OP_RD_NACK : OP_RD_ACK;
              st <= S_RD;
            end else begin
              st <= S_WR;
            end
          end
          S_WR: begin
            if (op_valid) begin
              if (op_done) begin
                cnt <= cnt - CNT_ONE;
                if (cnt == CNT_ONE) st <= S_END;
              end
            end else if (tx_valid) begin
              op_valid <= 1'b1; op_code <= OP_WRITE; op_data <= tx_data;
            end
          end
          S_RD: if (op_done) begin
            rx_data <= op_rdata; rx_valid <= 1'b1; st <= S_RXO;
          end
          S_RXO: if (rx_ready) begin
            rx_valid <= 1'b0; cnt <= cnt - CNT_ONE; st <= S_DATA;
          end
          S_END: begin
            if (c_sto) begin
              op_valid <= 1'b1; op_code <= OP_STOP; op_data <= '0;
              held <= 1'b0; st <= S_STOP;
            end else begin
              st <= S_FIN;
            end
          end
          S_STOP: if (op_done) st <= S_FIN;
          S_FIN: begin
            done <= 1'b1;
            st   <= nxt_valid ? S_LOAD : S_IDLE;
          end
          S_ABRT: if (op_done) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R9
  nack_stops_chk: assert property (@(posedge clk) disable iff (rst)
    nack_err |-> (op_valid && op_code == OP_STOP));
  // R10
  mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    mode_err |-> !op_valid);
  // R11
  done_clean_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!nack_err && !mode_err));
  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
  // R1
  op_legal_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> (op_code inside {OP_START, OP_RSTART, OP_WRITE,
                                  OP_RD_ACK, OP_RD_NACK, OP_STOP}));
endmodule

// File: tb/tb_i2c_addr_seq.sv
`timescale 1ns/1ps
module tb_i2c_addr_seq;
  import i2c_seq_pkg::*;
  localparam int NBW   = 8;
  localparam int CMD_W = F_NB + NBW;

  logic clk = 1'b0, rst = 1'b1, smbus_mode = 1'b0;
  logic cur_wr = 1'b0, nxt_wr = 1'b0;
  logic [CMD_W-1:0] cur_cmd = '0, nxt_cmd = '0;
  logic busy, done, nack_err, mode_err, op_valid, tx_ready, rx_valid;
  logic [2:0] op_code;
  logic [7:0] op_data, rx_data;
  logic op_done = 1'b0, op_nack = 1'b0, tx_valid = 1'b0, rx_ready = 1'b0;
  logic [7:0] op_rdata = '0, tx_data = '0;

  always #4 clk = ~clk;

  i2c_addr_seq #(.NBW(NBW)) dut (
    .clk(clk), .rst(rst), .smbus_mode(smbus_mode),
    .cur_wr(cur_wr), .cur_cmd(cur_cmd), .nxt_wr(nxt_wr), .nxt_cmd(nxt_cmd),
    .busy(busy), .done(done), .nack_err(nack_err), .mode_err(mode_err),
    .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
    .op_done(op_done), .op_nack(op_nack), .op_rdata(op_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
  );

  int n_chk = 0, n_bad = 0;
  int done_n = 0, nerr_n = 0, merr_n = 0;
  int op_idx = 0, rd_idx = 0, nack_at = -1, lat = 0, rx_wait = 0;
  bit tx_take = 1'b0;
  string req = "R1";
  logic [10:0] exp_op[$];
  logic [7:0]  exp_rx[$];
  logic [7:0]  tx_q[$];

  function automatic logic [CMD_W-1:0] mk(logic [9:0] a, bit ten, bit rep,
      bit rd, bit sta, bit sto, logic [NBW-1:0] nb);
    return {nb, sto, sta, rd, rep, ten, a};
  endfunction

  task automatic chk(bit ok, string r, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic ex(op_e c, logic [7:0] d);
    exp_op.push_back({c, d});
  endtask

  // monitor: bit engine model, scoreboard, payload ports, pulse counters
  initial forever begin
    @(negedge clk);
    if (!rst) begin
      if (done) done_n++;
      if (nack_err) nerr_n++;
      if (mode_err) merr_n++;
      if (op_done) op_done = 1'b0;
      else if (lat > 0) begin
        lat--;
        if (lat == 0) op_done = 1'b1;
      end else if (op_valid) begin
        if (exp_op.size() == 0)
          chk(1'b0, req, "unexpected op", int'({op_code, op_data}), 0);
        else begin
          logic [10:0] e;
          e = exp_op.pop_front();
          chk({op_code, op_data} == e, req, "op", int'({op_code, op_data}), int'(e));
        end
        op_nack  = (op_idx == nack_at);
        op_rdata = 8'(8'hA0 + rd_idx);
        if (op_code == OP_RD_ACK || op_code == OP_RD_NACK) rd_idx++;
        op_idx++;
        lat = 2;
      end
      if (tx_take) void'(tx_q.pop_front());
      tx_valid = (tx_q.size() > 0);
      tx_data  = tx_valid ? tx_q[0] : 8'h00;
      tx_take  = tx_valid && tx_ready;
      if (rx_ready) begin
        rx_ready = 1'b0; rx_wait = 0;
      end else if (rx_valid) begin
        rx_wait++;
        if (rx_wait == 3) begin
          if (exp_rx.size() == 0) chk(1'b0, req, "unexpected rx", int'(rx_data), 0);
          else begin
            logic [7:0] r;
            r = exp_rx.pop_front();
            chk(rx_data == r, req, "rx byte", int'(rx_data), int'(r));
          end
          rx_ready = 1'b1;
        end
      end
    end
  end

  task automatic send(logic [CMD_W-1:0] c, bit has_nxt, logic [CMD_W-1:0] n);
    @(negedge clk);
    if (has_nxt) begin
      nxt_wr = 1'b1; nxt_cmd = n;
      @(negedge clk);
      nxt_wr = 1'b0;
    end
    cur_wr = 1'b1; cur_cmd = c;
    @(negedge clk);
    cur_wr = 1'b0;
  endtask

  task automatic settle(int e_done, int e_nerr, int e_merr);
    repeat (4) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (12) @(negedge clk);
    chk(exp_op.size() == 0, req, "ops left", exp_op.size(), 0);
    chk(exp_rx.size() == 0, req, "rx left", exp_rx.size(), 0);
    chk(done_n == e_done, req, "done pulses", done_n, e_done);
    chk(nerr_n == e_nerr, req, "nack_err pulses", nerr_n, e_nerr);
    chk(merr_n == e_merr, req, "mode_err pulses", merr_n, e_merr);
    done_n = 0; nerr_n = 0; merr_n = 0;
    op_idx = 0; rd_idx = 0; nack_at = -1;
    tx_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!busy && !op_valid && !done && !rx_valid && !tx_ready, "R1", "reset outputs",
        int'({busy, op_valid, done, rx_valid, tx_ready}), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R2 R6: 7-bit write, two bytes
    req = "R2/R6";
    tx_q.push_back(8'h11); tx_q.push_back(8'h22);
    ex(OP_START, 0); ex(OP_WRITE, 8'h54); ex(OP_WRITE, 8'h11); ex(OP_WRITE, 8'h22); ex(OP_STOP, 0);
    send(mk(10'h02A, 0, 0, 0, 1, 1, 2), 0, '0);
    settle(1, 0, 0);

    // R3: 10-bit write
    req = "R3";
    tx_q.push_back(8'h33);
    ex(OP_START, 0); ex(OP_WRITE, 8'hF4); ex(OP_WRITE, 8'hB5); ex(OP_WRITE, 8'h33); ex(OP_STOP, 0);
    send(mk(10'h2B5, 1, 0, 0, 1, 1, 1), 0, '0);
    settle(1, 0, 0);

    // R4 R5 R7 R8 R11: chained 10-bit read
    req = "R4/R5/R7/R11";
    ex(OP_START, 0); ex(OP_WRITE, 8'hF2); ex(OP_WRITE, 8'h7C);
    ex(OP_RSTART, 0); ex(OP_WRITE, 8'hF3);
    ex(OP_RD_ACK, 0); ex(OP_RD_ACK, 0); ex(OP_RD_NACK, 0); ex(OP_STOP, 0);
    exp_rx.push_back(8'hA0); exp_rx.push_back(8'hA1); exp_rx.push_back(8'hA2);
    send(mk(10'h17C, 1, 0, 0, 1, 0, 0), 1, mk(10'h17C, 1, 1, 1, 1, 1, 3));
    settle(2, 0, 0);

    // R9: NACK on a data byte with a queued command
    req = "R9";
    nack_at = 3;
    tx_q.push_back(8'h01); tx_q.push_back(8'h02); tx_q.push_back(8'h03);
    ex(OP_START, 0); ex(OP_WRITE, 8'hA0); ex(OP_WRITE, 8'h01); ex(OP_WRITE, 8'h02); ex(OP_STOP, 0);
    send(mk(10'h050, 0, 0, 0, 1, 1, 3), 1, mk(10'h010, 0, 0, 0, 1, 1, 0));
    settle(0, 1, 0);
    // R9: discarded queued command must not run after the next one
    ex(OP_START, 0); ex(OP_WRITE, 8'h24); ex(OP_STOP, 0);
    send(mk(10'h012, 0, 0, 0, 1, 1, 0), 0, '0);
    settle(1, 0, 0);

    // R9: NACK on the 10-bit header
    nack_at = 1;
    tx_q.push_back(8'h44);
    ex(OP_START, 0); ex(OP_WRITE, 8'hF6); ex(OP_STOP, 0);
    send(mk(10'h3FF, 1, 0, 0, 1, 1, 1), 0, '0);
    settle(0, 1, 0);

    // R10: 10-bit rejected in SMBus mode, queued entry dropped
    req = "R10";
    smbus_mode = 1'b1;
    send(mk(10'h100, 1, 0, 0, 1, 1, 1), 1, mk(10'h033, 0, 0, 0, 1, 1, 0));
    settle(0, 0, 1);
    // R8 R10: 7-bit zero-length command still runs in SMBus mode
    req = "R8/R10";
    ex(OP_START, 0); ex(OP_WRITE, 8'h66); ex(OP_STOP, 0);
    send(mk(10'h033, 0, 0, 0, 1, 1, 0), 0, '0);
    settle(1, 0, 0);
    smbus_mode = 1'b0;

    // R7: 7-bit single-byte read
    req = "R7";
    ex(OP_START, 0); ex(OP_WRITE, 8'h8B); ex(OP_RD_NACK, 0); ex(OP_STOP, 0);
    exp_rx.push_back(8'hA0);
    send(mk(10'h045, 0, 0, 1, 1, 1, 1), 0, '0);
    settle(1, 0, 0);

    // R8 R5: hold the bus, then reopen with repeated start
    req = "R8";
    tx_q.push_back(8'h5A);
    ex(OP_START, 0); ex(OP_WRITE, 8'h1E); ex(OP_WRITE, 8'h5A);
    send(mk(10'h00F, 0, 0, 0, 1, 0, 1), 0, '0);
    settle(1, 0, 0);
    chk(!busy, "R8", "busy while held", int'(busy), 0);
    req = "R5";
    ex(OP_RSTART, 0); ex(OP_WRITE, 8'h1E); ex(OP_STOP, 0);
    send(mk(10'h00F, 0, 0, 0, 1, 1, 0), 0, '0);
    settle(1, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule